// File: doc/BRIEF.md
# Trap Entry and Vector Unit

This block keeps the processor-mode fields (supervisor, previous supervisor, trap enable, interrupt priority threshold, current window pointer) and the trap base register. It also performs the one-cycle state change for trap entry. A synchronous trap request carries an 8-bit trap type. An interrupt is presented as a 4-bit pending level, where level 0 means nothing is pending. When traps are enabled, a trap request or an accepted interrupt is taken at the next clock edge.

On that edge the unit performs the following updates together:
- It copies the supervisor bit into the previous-supervisor bit.
- It enters supervisor mode.
- It clears the trap-enable bit.
- It steps the window pointer down by one, wrapping modulo the window count.
- It latches the trap type into the hardware-owned field of the trap base register.

The vector address is the read value of the trap base register: the 20-bit base, then the 8-bit type, then four zero bits. `trap_taken_o` pulses in the cycle where the new state and vector are visible.

Software loads the 20-bit base through one write port and the mode fields through another. Fetching from the vector, saving the program counters and executing instructions are done elsewhere.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset: supervisor 1, previous supervisor 0, trap enable 0, interrupt threshold 0, window pointer 0, error mode 0, `trap_taken_o` 0, `vector_o` all zero.
- R2: A trap taken while trap enable is 1 produces the following one clock later: `trap_taken_o` is 1 for exactly one cycle, `s_o` is 1, `et_o` is 0, and `ps_o` equals the `s_o` value from before the edge.
- R3: Each trap taken moves `cwp_o` down by one, and from 0 it wraps to NWIN-1.
- R4: `vector_o` is {base[19:0], tt[7:0], 4'b0000}. After a synchronous trap, tt equals `trap_type_i`.
- R5: An interrupt level L is accepted when L is nonzero and either L > `pil_o` or L == 15. `irq_accept_o` is 1 exactly when trap enable is 1 and L is accepted. An accepted interrupt is taken with tt = 0x10 + L.
- R6: When a trap request and an accepted interrupt arrive in the same cycle, the trap request is taken and the interrupt is not.
- R7: A trap request while trap enable is 0 sets `error_mode_o`, which stays set until reset, and leaves all other state unchanged. An interrupt while trap enable is 0 has no effect.
- R8: A base write replaces only the top 20 bits of `vector_o`; the tt field keeps its value.
- R9: A state write loads threshold, supervisor, trap enable and window pointer. If a trap is taken in the same cycle, the trap entry update wins and the state write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trap_req_i | input | 1 | Synchronous trap request |
| trap_type_i | input | 8 | Trap type of the request |
| irq_level_i | input | 4 | Pending interrupt level, 0 = none |
| base_we_i | input | 1 | Write strobe for the trap table base |
| base_wdata_i | input | 20 | New trap table base |
| state_we_i | input | 1 | Write strobe for the mode fields |
| state_pil_i | input | 4 | New interrupt threshold |
| state_s_i | input | 1 | New supervisor bit |
| state_et_i | input | 1 | New trap enable bit |
| state_cwp_i | input | CWP_W | New window pointer, must be below NWIN |
| vector_o | output | 32 | Trap base register read value and vector address |
| trap_taken_o | output | 1 | One-cycle pulse after trap entry |
| irq_accept_o | output | 1 | Current interrupt level is accepted |
| s_o | output | 1 | Supervisor bit, 1 = supervisor |
| ps_o | output | 1 | Previous supervisor bit |
| et_o | output | 1 | Trap enable bit |
| pil_o | output | 4 | Interrupt threshold |
| cwp_o | output | CWP_W | Current window pointer |
| error_mode_o | output | 1 | Trap requested while traps were disabled |

## Verification
The assertions assume that `state_cwp_i` is always below NWIN when it is written, and that every input is free of X/Z after reset. The wrap check and the one-pulse check rely on this. The stimulus only writes legal window values and drives every input to a defined value at every falling edge. It covers the wrap from 0, an interrupt level equal to the threshold, level 15 against a threshold of 15, and a trap request that arrives together with an interrupt or a state write.

// File: rtl/tentry_pkg.sv
package tentry_pkg;
  localparam int unsigned TBA_W   = 20;
  localparam int unsigned TT_W    = 8;
  localparam int unsigned PIL_W   = 4;
  localparam int unsigned VZERO_W = 4;
  localparam int unsigned VEC_W   = TBA_W + TT_W + VZERO_W;
  localparam logic [TT_W-1:0]  IRQ_TT_BASE = 8'h10;
  localparam logic [PIL_W-1:0] PIL_NMI     = '1;
endpackage

// File: rtl/tentry_irq_arb.sv
module tentry_irq_arb
  import tentry_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             et_i,
  input  logic [PIL_W-1:0] pil_i,
  input  logic [PIL_W-1:0] lvl_i,
  input  logic             treq_i,
  input  logic [TT_W-1:0]  ttype_i,
  output logic             accept_o,
  output logic             take_o,
  output logic [TT_W-1:0]  tt_o
);
  logic lvl_ok;

  always_comb begin
    lvl_ok   = (lvl_i != '0) && ((lvl_i > pil_i) || (lvl_i == PIL_NMI));
    accept_o = et_i && lvl_ok;
    take_o   = et_i && (treq_i || lvl_ok);
    // synchronous request outranks interrupt
    tt_o     = treq_i ? ttype_i : (IRQ_TT_BASE + TT_W'(lvl_i));
  end

  assert_no_irq_at_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i == '0) |-> !accept_o);
  assert_sync_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && treq_i) |-> (tt_o == ttype_i));
endmodule

// File: rtl/tentry_win_step.sv
module tentry_win_step #(
  parameter int unsigned NWIN  = 8,
  parameter int unsigned CWP_W = $clog2(NWIN)
) (
  input  logic [CWP_W-1:0] cwp_i,
  output logic [CWP_W-1:0] cwp_o
);
  localparam bit POW2 = ((1 << CWP_W) == NWIN);

  generate
    if (POW2) begin : g_pow2
      assign cwp_o = cwp_i - 1'b1;
    end else begin : g_wrap
      assign cwp_o = (cwp_i == '0) ? CWP_W'(NWIN - 1) : (cwp_i - 1'b1);
    end
  endgenerate
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import tentry_pkg::*;
#(
  parameter int unsigned NWIN  = 8,
  parameter int unsigned CWP_W = $clog2(NWIN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trap_req_i,
  input  logic [7:0]       trap_type_i,
  input  logic [3:0]       irq_level_i,
  input  logic             base_we_i,
  input  logic [19:0]      base_wdata_i,
  input  logic             state_we_i,
  input  logic [3:0]       state_pil_i,
  input  logic             state_s_i,
  input  logic             state_et_i,
  input  logic [CWP_W-1:0] state_cwp_i,
  output logic [31:0]      vector_o,
  output logic             trap_taken_o,
  output logic             irq_accept_o,
  output logic             s_o,
  output logic             ps_o,
  output logic             et_o,
  output logic [3:0]       pil_o,
  output logic [CWP_W-1:0] cwp_o,
  output logic             error_mode_o
);
  logic [TBA_W-1:0] tba_q;
  logic [TT_W-1:0]  tt_q, tt_d;
  logic             s_q, ps_q, et_q, err_q, taken_q, take;
  logic [PIL_W-1:0] pil_q;
  logic [CWP_W-1:0] cwp_q, cwp_dec;

  tentry_irq_arb u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .et_i     (et_q),
    .pil_i    (pil_q),
    .lvl_i    (irq_level_i),
    .treq_i   (trap_req_i),
    .ttype_i  (trap_type_i),
    .accept_o (irq_accept_o),
    .take_o   (take),
    .tt_o     (tt_d)
  );

  tentry_win_step #(.NWIN(NWIN), .CWP_W(CWP_W)) u_win (
    .cwp_i (cwp_q),
    .cwp_o (cwp_dec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_q     <= 1'b1;
      ps_q    <= 1'b0;
      et_q    <= 1'b0;
      pil_q   <= '0;
      cwp_q   <= '0;
      tt_q    <= '0;
      taken_q <= 1'b0;
    end else begin
      taken_q <= take;
      if (take) begin
        ps_q  <= s_q;
        s_q   <= 1'b1;
        et_q  <= 1'b0;
        cwp_q <= cwp_dec;
        tt_q  <= tt_d;
      end else if (state_we_i) begin
        pil_q <= state_pil_i;
        s_q   <= state_s_i;
        et_q  <= state_et_i;
        cwp_q <= state_cwp_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tba_q <= '0;
    else if (base_we_i) tba_q <= base_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   err_q <= 1'b0;
    else if (trap_req_i && !et_q)  err_q <= 1'b1;
  end

  assign vector_o     = {tba_q, tt_q, {VZERO_W{1'b0}}};
  assign trap_taken_o = taken_q;
  assign s_o          = s_q;
  assign ps_o         = ps_q;
  assign et_o         = et_q;
  assign pil_o        = pil_q;
  assign cwp_o        = cwp_q;
  assign error_mode_o = err_q;

  assert_entry_mode_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_taken_o |-> (s_o && !et_o && (ps_o == $past(s_o))));
  assert_single_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_taken_o |=> !trap_taken_o);
  assert_cwp_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_taken_o |-> (cwp_o == (($past(cwp_o) == '0) ? CWP_W'(NWIN - 1)
                                                      : CWP_W'($past(cwp_o) - 1'b1))));
  assert_cwp_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cwp_o) < NWIN);
  assert_err_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (error_mode_o || (trap_req_i && !et_o)) |=> error_mode_o);
  assert_base_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !base_we_i |=> $stable(vector_o[31:12]));
  assert_tt_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !et_o |=> $stable(vector_o[11:4]));
endmodule

// File: tb/sim_trap_entry_unit.sv
`timescale 1ns/1ps
module sim_trap_entry_unit;
  localparam int NWIN = 8;
  localparam int CW   = $clog2(NWIN);

  typedef struct {
    logic [31:0]   vec;
    logic          taken, s, ps, et, err;
    logic [3:0]    pil;
    logic [CW-1:0] cwp;
    string         tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic trap_req = 0, base_we = 0, state_we = 0, st_s = 0, st_et = 0;
  logic [7:0] trap_type = 0;
  logic [3:0] lvl = 0, st_pil = 0;
  logic [19:0] base_wd = 0;
  logic [CW-1:0] st_cwp = 0;
  logic [31:0] vector;
  logic taken, irq_acc, s, ps, et, err;
  logic [3:0] pil;
  logic [CW-1:0] cwp;

  always #5 clk = ~clk;

  trap_entry_unit #(.NWIN(NWIN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .trap_req_i(trap_req), .trap_type_i(trap_type),
    .irq_level_i(lvl), .base_we_i(base_we), .base_wdata_i(base_wd),
    .state_we_i(state_we), .state_pil_i(st_pil), .state_s_i(st_s),
    .state_et_i(st_et), .state_cwp_i(st_cwp), .vector_o(vector),
    .trap_taken_o(taken), .irq_accept_o(irq_acc), .s_o(s), .ps_o(ps),
    .et_o(et), .pil_o(pil), .cwp_o(cwp), .error_mode_o(err));

  exp_t q[$];
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // reference state
  logic m_s = 1, m_ps = 0, m_et = 0, m_err = 0;
  logic [3:0] m_pil = 0;
  logic [CW-1:0] m_cwp = 0;
  logic [19:0] m_tba = 0;
  logic [7:0] m_tt = 0;

  task automatic step(input string tag, input logic tr, input logic [7:0] ty,
                      input logic [3:0] l, input logic bw, input logic [19:0] bd,
                      input logic sw, input logic [3:0] sp, input logic ss,
                      input logic se, input logic [CW-1:0] sc);
    exp_t e;
    logic lok, tk;
    @(negedge clk);
    trap_req = tr; trap_type = ty; lvl = l; base_we = bw; base_wd = bd;
    state_we = sw; st_pil = sp; st_s = ss; st_et = se; st_cwp = sc;
    lok = (l != 0) && ((l > m_pil) || (l == 4'd15));
    #1;
    n_vec++;
    if (irq_acc !== (m_et && lok)) begin
      n_bad++;
      $display("FAIL R5 %s irq_accept_o act=%b exp=%b", tag, irq_acc, m_et && lok);
    end
    tk = m_et && (tr || lok);
    if (tr && !m_et) m_err = 1;
    if (tk) begin
      m_ps = m_s; m_s = 1; m_et = 0;
      m_cwp = (m_cwp == 0) ? CW'(NWIN - 1) : m_cwp - 1;
      m_tt = tr ? ty : (8'h10 + {4'b0, l});
    end else if (sw) begin
      m_pil = sp; m_s = ss; m_et = se; m_cwp = sc;
    end
    if (bw) m_tba = bd;
    @(posedge clk);
    e.vec = {m_tba, m_tt, 4'b0}; e.taken = tk; e.s = m_s; e.ps = m_ps;
    e.et = m_et; e.err = m_err; e.pil = m_pil; e.cwp = m_cwp; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 8'h00, 4'd0, 0, 20'h0, 0, 4'd0, 0, 0, '0);
  endtask

  task automatic wr_state(input string tag, input logic [3:0] p, input logic sv,
                          input logic en, input logic [CW-1:0] c);
    step(tag, 0, 8'h00, 4'd0, 0, 20'h0, 1, p, sv, en, c);
  endtask

  // monitor: compare registered outputs one cycle after each drive
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_vec++;
      if (vector !== e.vec || taken !== e.taken || s !== e.s || ps !== e.ps ||
          et !== e.et || err !== e.err || pil !== e.pil || cwp !== e.cwp) begin
        n_bad++;
        $display("FAIL %s act vec=%h tk=%b s=%b ps=%b et=%b err=%b pil=%0d cwp=%0d exp vec=%h tk=%b s=%b ps=%b et=%b err=%b pil=%0d cwp=%0d",
                 e.tag, vector, taken, s, ps, et, err, pil, cwp,
                 e.vec, e.taken, e.s, e.ps, e.et, e.err, e.pil, e.cwp);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    idle("R1_reset");
    idle("R1_idle");
    step("R8_base", 0, 0, 0, 1, 20'hABCDE, 0, 0, 0, 0, '0);
    wr_state("R9_state", 4'd5, 0, 1, '0);
    step("R3_wrap_R4", 1, 8'h2A, 0, 0, 20'h0, 0, 0, 0, 0, '0);
    idle("R2_pulse_once");
    step("R8_tt_kept", 0, 0, 0, 1, 20'h12345, 0, 0, 0, 0, '0);
    wr_state("R9_state2", 4'd5, 0, 1, 3'd3);
    step("R5_below", 0, 0, 4'd3, 0, 0, 0, 0, 0, 0, '0);
    step("R5_equal", 0, 0, 4'd5, 0, 0, 0, 0, 0, 0, '0);
    step("R5_above", 0, 0, 4'd6, 0, 0, 0, 0, 0, 0, '0);
    wr_state("R9_pil15", 4'd15, 0, 1, 3'd1);
    step("R5_14_vs_15", 0, 0, 4'd14, 0, 0, 0, 0, 0, 0, '0);
    step("R5_lvl15", 0, 0, 4'd15, 0, 0, 0, 0, 0, 0, '0);
    wr_state("R9_pil0", 4'd0, 0, 1, 3'd4);
    step("R6_sync_wins", 1, 8'h05, 4'd9, 0, 0, 0, 0, 0, 0, '0);
    step("R7_irq_ignored", 0, 0, 4'd12, 0, 0, 0, 0, 0, 0, '0);
    step("R7_err", 1, 8'h77, 0, 0, 0, 0, 0, 0, 0, '0);
    idle("R7_sticky");
    wr_state("R9_reen", 4'd2, 0, 1, 3'd6);
    step("R9_trap_beats_write", 1, 8'h81, 0, 0, 0, 1, 4'd9, 0, 1, 3'd2);
    for (int i = 0; i < 10; i++) begin
      wr_state("R9_loop", 4'(i), 1'(i), 1, CW'(i));
      step("R2_R3_loop", 1, 8'(8'h40 + i * 7), 0, (i % 3) == 0, 20'(i * 4097), 0, 0, 0, 0, '0);
    end
    idle("R4_drain");
    idle("R4_drain2");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule